// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical raster timing of a display pipe. A pixel counter and a line counter walk a frame whose geometry comes from six timing registers: one register for the active window, one for the blank window and one for the sync window on each axis. Each register holds two 16-bit fields, and every field is stored as a count minus one. Along each axis the raster runs through the active region, the front porch, the sync pulse and the back porch. The blank window starts where the active region ends, and the total length equals the blank end. From the counters the block drives hsync, vsync, hblank, vblank and a display-enable strobe. The sync pulses are active-high.

Software reaches the registers through a simple write port and a combinational read port. A key register guards all writes. A write of the key value opens the register file, and a write of any other value to the key register closes it again. Reprogramming runs in three steps: clear the generator-enable bit, write the new timing, then set the bit again. A running generator keeps its current geometry until the frame in progress ends. A stopped generator picks up new timing at once.

A two-state machine controls sequencing. In STOPPED both counters are held at zero and the syncs and display-enable are low. The START transition goes to RUNNING when the enable bit is seen set. The HALT transition returns to STOPPED when the bit is seen clear.

Top module: `vtg_core`

## Requirements
- R1: After reset the generator is STOPPED. pix_x and line_y are 0, hsync, vsync and disp_en are 0, hblank and vblank are 1, and every register reads 0.
- R2: Writes to addresses 1 to 7 are ignored unless the file is unlocked. Writing 32'h0000_4758 to address 0 unlocks it, and writing any other value to address 0 locks it. Reads of addresses 1 to 7 return the stored value in either lock state. Address 0 always reads 0.
- R3: The register map is as follows. Address 1 is control: bit 0 is generator enable, bit 1 is graphics enable and bit 2 is video enable. Addresses 2, 3 and 4 are the horizontal active, blank and sync registers. Addresses 5, 6 and 7 are the vertical active, blank and sync registers. In each timing register, bits 15:0 hold lo and bits 31:16 hold hi. The total length minus one is the hi field of the active register.
- R4: While RUNNING, pix_x advances by one each cycle. After reaching the horizontal total field, pix_x returns to 0 and line_y advances by one. After line_y reaches the vertical total field, it returns to 0.
- R5: hsync is high exactly when sync.lo < pix_x <= sync.hi of the horizontal sync register. vsync follows the same rule using line_y and the vertical sync register.
- R6: hblank is high exactly when blank.lo < pix_x <= blank.hi of the horizontal blank register. vblank follows the same rule on line_y.
- R7: disp_en is high only when all of the following hold: pix_x <= horizontal active lo, line_y <= vertical active lo, the generator is RUNNING, the graphics-enable bit is 1 and the video-enable bit is 1.
- R8: START: when the enable bit is seen set in STOPPED, the next cycle is RUNNING with both counters at 0. HALT: when the enable bit is seen clear in RUNNING, the next cycle is STOPPED with both counters at 0, the syncs and disp_en at 0, and the blanks at 1.
- R9: While RUNNING, timing-register writes take effect only after the cycle in which pix_x and line_y both equal their total fields. While STOPPED, new timing is taken up at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| hsync | output | 1 | Horizontal sync, active-high |
| vsync | output | 1 | Vertical sync, active-high |
| hblank | output | 1 | Horizontal blank window |
| vblank | output | 1 | Vertical blank window |
| disp_en | output | 1 | Display-enable strobe |
| pix_x | output | 16 | Pixel counter |
| line_y | output | 16 | Line counter |

## Verification
The bench programs a small mode of 15 pixels by 8 lines. It then probes cycles that sit on each window boundary: the last active pixel, the first blank pixel, the sync start, the sync end, the line wrap and the frame wrap. An off-by-one in any lo or hi comparison therefore moves an edge that is checked. A hsync change is written in the middle of a frame and observed both before and after the frame wrap, which separates deferred update from immediate update. A second change is made while the generator is stopped, which shows that a stopped generator applies new timing at once. Separate tests cover locked writes, a relock during a run, the video-enable gating of display-enable, and the HALT and START transitions, so a loss of write protection or of counter clearing is caught.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int REG_DW   = 32;
    localparam int CNT_W    = REG_DW / 2;
    localparam int NUM_REGS = 8;
    localparam int REG_AW   = $clog2(NUM_REGS);

    localparam int ADDR_KEY    = 0;
    localparam int ADDR_CTRL   = 1;
    localparam int ADDR_H_BASE = 2;
    localparam int ADDR_V_BASE = 5;

    localparam int CTRL_GEN = 0;
    localparam int CTRL_GFX = 1;
    localparam int CTRL_VID = 2;
    localparam int CTRL_W   = 3;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } span_t;

    typedef struct packed {
        span_t act;
        span_t blank;
        span_t sync;
    } axis_cfg_t;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } gen_state_t;
endpackage

// File: rtl/vtg_regfile.sv
module vtg_regfile
    import vtg_pkg::*;
#(
    parameter logic [REG_DW-1:0] UNLOCK_KEY = 32'h0000_4758
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    input  logic              frame_load,
    output logic [CTRL_W-1:0] ctrl,
    output logic              unlocked,
    output axis_cfg_t         h_cfg,
    output axis_cfg_t         v_cfg
);
    logic [REG_DW-1:0] reg_q [NUM_REGS];
    logic              unlocked_q;
    axis_cfg_t         h_live, v_live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked_q <= 1'b0;
        end else if (wr_en && wr_addr == REG_AW'(ADDR_KEY)) begin
            unlocked_q <= (wr_data == UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) reg_q[i] <= '0;
        end else begin
            for (int i = 1; i < NUM_REGS; i++) begin
                if (wr_en && unlocked_q && wr_addr == REG_AW'(i))
                    reg_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = reg_q[rd_addr];
    assign ctrl    = reg_q[ADDR_CTRL][CTRL_W-1:0];
    assign unlocked = unlocked_q;

    assign h_live = axis_cfg_t'({reg_q[ADDR_H_BASE], reg_q[ADDR_H_BASE+1], reg_q[ADDR_H_BASE+2]});
    assign v_live = axis_cfg_t'({reg_q[ADDR_V_BASE], reg_q[ADDR_V_BASE+1], reg_q[ADDR_V_BASE+2]});

    // Working copy of the geometry, refreshed only at frame boundaries or while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cfg <= '0;
            v_cfg <= '0;
        end else if (frame_load) begin
            h_cfg <= h_live;
            v_cfg <= v_live;
        end
    end
endmodule

// File: rtl/vtg_window.sv
module vtg_window
    import vtg_pkg::*;
(
    input  logic [CNT_W-1:0] pos,
    input  axis_cfg_t        cfg,
    output logic             in_sync,
    output logic             in_blank,
    output logic             in_active
);
    // Windows are half-open from the lo field: lo < pos <= hi
    assign in_sync   = (pos > cfg.sync.lo)  && (pos <= cfg.sync.hi);
    assign in_blank  = (pos > cfg.blank.lo) && (pos <= cfg.blank.hi);
    assign in_active = (pos <= cfg.act.lo);
endmodule

// File: rtl/vtg_core.sv
module vtg_core
    import vtg_pkg::*;
#(
    parameter logic [REG_DW-1:0] UNLOCK_KEY = 32'h0000_4758
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    output logic              hsync,
    output logic              vsync,
    output logic              hblank,
    output logic              vblank,
    output logic              disp_en,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  line_y
);
    gen_state_t        state_q, state_d;
    logic [CTRL_W-1:0] ctrl;
    logic              unlocked;
    axis_cfg_t         h_cfg, v_cfg;
    logic [CNT_W-1:0]  x_q, y_q;
    logic              running, line_end, frame_end, frame_load;
    logic              h_sync_w, h_blank_w, h_act_w;
    logic              v_sync_w, v_blank_w, v_act_w;

    vtg_regfile #(.UNLOCK_KEY(UNLOCK_KEY)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .frame_load (frame_load),
        .ctrl       (ctrl),
        .unlocked   (unlocked),
        .h_cfg      (h_cfg),
        .v_cfg      (v_cfg)
    );

    vtg_window u_hwin (
        .pos(x_q), .cfg(h_cfg),
        .in_sync(h_sync_w), .in_blank(h_blank_w), .in_active(h_act_w)
    );

    vtg_window u_vwin (
        .pos(y_q), .cfg(v_cfg),
        .in_sync(v_sync_w), .in_blank(v_blank_w), .in_active(v_act_w)
    );

    assign running    = (state_q == ST_RUNNING);
    assign line_end   = (x_q == h_cfg.act.hi);
    assign frame_end  = line_end && (y_q == v_cfg.act.hi);
    assign frame_load = !running || frame_end;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // Transitions: START and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (ctrl[CTRL_GEN])  state_d = ST_RUNNING;
            ST_RUNNING: if (!ctrl[CTRL_GEN]) state_d = ST_STOPPED;
        endcase
    end

    // Raster counters, cleared whenever the next state is STOPPED or just started
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (running && state_d == ST_RUNNING) begin
            if (line_end) begin
                x_q <= '0;
                y_q <= (y_q == v_cfg.act.hi) ? '0 : y_q + 1'b1;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end else begin
            x_q <= '0;
            y_q <= '0;
        end
    end

    // Outputs per state
    always_comb begin
        unique case (state_q)
            ST_STOPPED: begin
                hsync   = 1'b0;
                vsync   = 1'b0;
                hblank  = 1'b1;
                vblank  = 1'b1;
                disp_en = 1'b0;
            end
            ST_RUNNING: begin
                hsync   = h_sync_w;
                vsync   = v_sync_w;
                hblank  = h_blank_w;
                vblank  = v_blank_w;
                disp_en = h_act_w && v_act_w && ctrl[CTRL_GFX] && ctrl[CTRL_VID];
            end
        endcase
    end

    assign pix_x  = x_q;
    assign line_y = y_q;
endmodule

// File: rtl/vtg_core_chk.sv
module vtg_core_chk
    import vtg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic [CNT_W-1:0]  pix_x,
    input logic [CNT_W-1:0]  line_y,
    input logic              hsync,
    input logic              vsync,
    input logic              disp_en,
    input logic [CTRL_W-1:0] ctrl,
    input logic              unlocked,
    input axis_cfg_t         h_cfg,
    input axis_cfg_t         v_cfg
);
    assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!hsync && !vsync && !disp_en && pix_x == '0 && line_y == '0));

    assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ctrl[CTRL_GEN]) |=> !running);

    assert_pixel_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pix_x != h_cfg.act.hi) |=> (!running || pix_x == $past(pix_x) + 16'd1));

    assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pix_x != h_cfg.act.hi) |=> (!running || line_y == $past(line_y)));

    assert_de_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |-> (ctrl[CTRL_GFX] && ctrl[CTRL_VID]));

    assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(ctrl));

    assert_frame_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(pix_x == h_cfg.act.hi && line_y == v_cfg.act.hi))
            |=> ($stable(h_cfg) && $stable(v_cfg)));
endmodule

bind vtg_core vtg_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .pix_x    (pix_x),
    .line_y   (line_y),
    .hsync    (hsync),
    .vsync    (vsync),
    .disp_en  (disp_en),
    .ctrl     (ctrl),
    .unlocked (unlocked),
    .h_cfg    (h_cfg),
    .v_cfg    (v_cfg)
);

// File: tb/vtg_core_tb.sv
`timescale 1ns/1ps
module vtg_core_tb_top;
    import vtg_pkg::*;

    localparam logic [31:0] KEY = 32'h0000_4758;

    typedef struct packed {
        int          cyc;
        logic [15:0] x;
        logic [15:0] y;
        logic        hs;
        logic        hb;
        logic        vs;
        logic        vb;
        logic        de;
    } vec_t;

    // Mode: H total 15 (active 8, blank 8..14, sync 10..12); V total 8 (active 4, blank 4..7, sync 5..6)
    localparam int NVEC = 16;
    localparam vec_t VEC [NVEC] = '{
        '{0,   16'd0,  16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{7,   16'd7,  16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{8,   16'd8,  16'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{9,   16'd9,  16'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{10,  16'd10, 16'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{12,  16'd12, 16'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{13,  16'd13, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{14,  16'd14, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{15,  16'd0,  16'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{52,  16'd7,  16'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{60,  16'd0,  16'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{75,  16'd0,  16'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{90,  16'd0,  16'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{105, 16'd0,  16'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{119, 16'd14, 16'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{120, 16'd0,  16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        hsync, vsync, hblank, vblank, disp_en;
    logic [15:0] pix_x, line_y;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vtg_core dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync), .vsync(vsync),
        .hblank(hblank), .vblank(vblank), .disp_en(disp_en), .pix_x(pix_x), .line_y(line_y)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_xy(input logic [15:0] x, input logic [15:0] y);
        int n = 0;
        @(negedge clk);
        while (!(pix_x == x && line_y == y) && n < 400) begin
            @(negedge clk);
            n++;
        end
        check("R4 wait_xy reached", {15'd0, (n < 400)}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [15:0] x0;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 hsync", {31'd0, hsync}, 32'd0);
        check("R1 vsync", {31'd0, vsync}, 32'd0);
        check("R1 disp_en", {31'd0, disp_en}, 32'd0);
        check("R1 blanks", {30'd0, hblank, vblank}, 32'd3);
        check("R1 counters", {pix_x, line_y}, 32'd0);
        rd(3'd1, r); check("R1 ctrl reads 0", r, 32'd0);

        // R2 locked write ignored
        wr(3'd2, 32'h1234_5678);
        rd(3'd2, r); check("R2 locked write ignored", r, 32'd0);

        // Unlock and program the mode
        wr(3'd0, KEY);
        wr(3'd2, (32'd14 << 16) | 32'd7);
        wr(3'd3, (32'd14 << 16) | 32'd7);
        wr(3'd4, (32'd12 << 16) | 32'd9);
        wr(3'd5, (32'd7 << 16) | 32'd3);
        wr(3'd6, (32'd7 << 16) | 32'd3);
        wr(3'd7, (32'd6 << 16) | 32'd4);
        rd(3'd4, r); check("R3 H sync readback", r, 32'h000C_0009);
        rd(3'd7, r); check("R3 V sync readback", r, 32'h0006_0004);
        rd(3'd0, r); check("R2 key reads 0", r, 32'd0);

        // R8 START then walk the vector table
        wr(3'd1, 32'd7);
        @(negedge clk);
        n = 0;
        for (int i = 0; i < NVEC; i++) begin
            while (n < VEC[i].cyc) begin
                @(negedge clk);
                n++;
            end
            check("R4 R8 pix_x", {16'd0, pix_x}, {16'd0, VEC[i].x});
            check("R4 line_y", {16'd0, line_y}, {16'd0, VEC[i].y});
            check("R5 hsync", {31'd0, hsync}, {31'd0, VEC[i].hs});
            check("R5 vsync", {31'd0, vsync}, {31'd0, VEC[i].vs});
            check("R6 hblank", {31'd0, hblank}, {31'd0, VEC[i].hb});
            check("R6 vblank", {31'd0, vblank}, {31'd0, VEC[i].vb});
            check("R7 disp_en", {31'd0, disp_en}, {31'd0, VEC[i].de});
        end

        // R2 relock, then ctrl write ignored while running
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        rd(3'd1, r); check("R2 relocked ctrl kept", r, 32'd7);
        x0 = pix_x;
        @(negedge clk);
        check("R2 R4 still counting", {16'd0, pix_x}, {16'd0, (x0 == 16'd14) ? 16'd0 : x0 + 16'd1});

        // R9 mid-frame hsync change applies at next frame
        wr(3'd0, KEY);
        wait_xy(16'd0, 16'd1);
        wr(3'd4, (32'd13 << 16) | 32'd10);
        wait_xy(16'd10, 16'd2);
        check("R9 old hsync kept mid-frame", {31'd0, hsync}, 32'd1);
        wait_xy(16'd10, 16'd0);
        check("R9 new hsync off at x10", {31'd0, hsync}, 32'd0);
        wait_xy(16'd13, 16'd0);
        check("R9 new hsync on at x13", {31'd0, hsync}, 32'd1);

        // R7 video-enable gating
        wr(3'd1, 32'd3);
        wait_xy(16'd0, 16'd0);
        check("R7 de off without video enable", {31'd0, disp_en}, 32'd0);
        check("R6 still active region", {31'd0, hblank}, 32'd0);
        wr(3'd1, 32'd7);
        wait_xy(16'd0, 16'd0);
        check("R7 de restored", {31'd0, disp_en}, 32'd1);

        // R8 HALT
        wr(3'd1, 32'd0);
        @(negedge clk);
        check("R8 halt counters", {pix_x, line_y}, 32'd0);
        check("R8 halt syncs and de", {29'd0, hsync, vsync, disp_en}, 32'd0);
        check("R8 halt blanks", {30'd0, hblank, vblank}, 32'd3);
        repeat (3) @(negedge clk);
        check("R8 held at zero", {pix_x, line_y}, 32'd0);

        // R9 immediate take-up while stopped, R8 restart from zero
        wr(3'd4, (32'd12 << 16) | 32'd9);
        wr(3'd1, 32'd7);
        @(negedge clk);
        check("R8 restart at zero", {pix_x, line_y}, 32'd0);
        wait_xy(16'd10, 16'd0);
        check("R9 stopped update applied x10", {31'd0, hsync}, 32'd1);
        wait_xy(16'd13, 16'd0);
        check("R9 stopped update applied x13", {31'd0, hsync}, 32'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule